// File: doc/BRIEF.md
# CPU Clock Path Switching Sequencer

This block owns the clock-select control word of one CPU cluster and steps it through a fixed order whenever the cluster's frequency changes. A request carries a target frequency in MHz. The sequencer checks it, moves the cluster onto a backup PLL and signals the droop-control logic. It then asks the primary PLL to retune and waits for lock. Last, it chooses the output path, either the halved primary output through the secondary mux or the droop-monitored full-rate primary output.

Targets under 600 MHz run the primary PLL at twice the target and take the divide-by-two path. Targets at or above 600 MHz run the PLL at the target itself. A request whose target is under 300 MHz, or whose PLL rate would fall outside 600 to 3000 MHz, is rejected and the control word is left as it was. If lock does not arrive within a programmable number of cycles, the cluster stays on the backup PLL and the block raises an error.

Top module: `cpu_clk_path_seq`

## Requirements
- R1: After reset the primary select is 0 (secondary mux), the secondary select is 0 (crystal), busy is low and req_ready is high.
- R2: A target below 300 MHz gives a one-cycle err pulse in the cycle after acceptance, with busy low and both selects unchanged.
- R3: A target whose PLL rate exceeds 3000 MHz (target above 3000) is rejected in the same way as R2.
- R4: In the cycle after a valid request is accepted, the primary select is 3 (backup PLL), and droop_wr pulses for that one cycle with droop_data equal to 0xF.
- R5: One cycle after parking, retune_req rises with retune_mhz equal to twice the target for targets below 600, and equal to the target otherwise. retune_req is high only while the primary select is 3.
- R6: For a target from 300 to 599 MHz, after lock the secondary select becomes 1 (primary divided by two) while the primary select is still 3. One cycle later the primary select becomes 0.
- R7: For a target from 600 to 3000 MHz, after lock the primary select becomes 2 (droop-monitored PLL) and the secondary select keeps its earlier value.
- R8: If pll_lock stays low for lock_limit+1 cycles after retune_req rises, err pulses, retune_req falls, busy falls and the primary select stays 3.
- R9: While busy is high, req_ready is low and a new request has no effect on retune_mhz, the selects or the path chosen.
- R10: The primary and secondary selects never change in the same cycle. The primary select leaves 3 only in the cycle where done pulses.
- R11: On completion, done pulses for one cycle and busy falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | High when a request can be accepted |
| req_mhz | input | FW (12) | Target frequency in MHz |
| lock_limit | input | TW (16) | Lock wait limit in cycles |
| pll_lock | input | 1 | Primary PLL lock indication |
| retune_req | output | 1 | Retune request to the primary PLL |
| retune_mhz | output | FW+1 (13) | PLL rate to program, in MHz |
| pmux_sel | output | 2 | Primary select: 0 secondary mux, 1 raw PLL, 2 droop-monitored PLL, 3 backup PLL |
| smux_sel | output | 2 | Secondary select: 0 crystal, 1 PLL divided by two |
| droop_wr | output | 1 | Write strobe to the cluster droop-control register |
| droop_data | output | 4 | Data for that write (0xF) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection or timeout pulse |

## Verification
The bench keeps the default widths (12-bit frequency, 16-bit wait counter) and the default 300/600/3000 MHz limits. It drives lock_limit to 20. This makes the timeout path reachable in a few dozen cycles, so the exact cycle of the err pulse can be checked. The 12-bit request field reaches past 3000 MHz, so the upper rejection edge is tested at 3000 and 3001. The lower edges are tested at 299/300 and 599/600.

// File: rtl/cpu_clk_seq_pkg.sv
package cpu_clk_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PARK,
    ST_TUNE,
    ST_SSEL,
    ST_PSEL
  } seq_state_t;

  localparam logic [1:0] PSEL_SEC    = 2'd0;
  localparam logic [1:0] PSEL_RAW    = 2'd1;
  localparam logic [1:0] PSEL_DROOP  = 2'd2;
  localparam logic [1:0] PSEL_BACKUP = 2'd3;
  localparam logic [1:0] SSEL_XO     = 2'd0;
  localparam logic [1:0] SSEL_HALF   = 2'd1;
  localparam logic [3:0] DROOP_VAL   = 4'hF;
endpackage

// File: rtl/cpu_clk_req_check.sv
module cpu_clk_req_check #(
  parameter int FW      = 12,
  parameter int MIN_MHZ = 300,
  parameter int LOW_MHZ = 600,
  parameter int PLL_MIN = 600,
  parameter int PLL_MAX = 3000
) (
  input  logic [FW-1:0] mhz,
  output logic          ok,
  output logic          low,
  output logic [FW:0]   pll_mhz
);
  localparam int PW = FW + 1;

  always_comb begin
    low     = ({1'b0, mhz} < PW'(LOW_MHZ));
    pll_mhz = low ? {mhz, 1'b0} : {1'b0, mhz};
    ok      = ({1'b0, mhz} >= PW'(MIN_MHZ)) &&
              (pll_mhz >= PW'(PLL_MIN)) &&
              (pll_mhz <= PW'(PLL_MAX));
  end
endmodule

// File: rtl/cpu_clk_lock_timer.sv
module cpu_clk_lock_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != limit) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == limit);
endmodule

// File: rtl/cpu_clk_seq_fsm.sv
module cpu_clk_seq_fsm
  import cpu_clk_seq_pkg::*;
#(
  parameter int FW = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_ok,
  input  logic        req_low,
  input  logic [FW:0] req_pll,
  input  logic        pll_lock,
  input  logic        expired,
  output logic        req_ready,
  output logic        tune_run,
  output logic        retune_req,
  output logic [FW:0] retune_mhz,
  output logic [1:0]  pmux_sel,
  output logic [1:0]  smux_sel,
  output logic        droop_wr,
  output logic [3:0]  droop_data,
  output logic        busy,
  output logic        done,
  output logic        err
);
  seq_state_t state;
  logic       low_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      low_q      <= 1'b0;
      retune_req <= 1'b0;
      retune_mhz <= '0;
      pmux_sel   <= PSEL_SEC;
      smux_sel   <= SSEL_XO;
      droop_wr   <= 1'b0;
      droop_data <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      droop_wr   <= 1'b0;
      droop_data <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (!req_ok) begin
              err <= 1'b1;
            end else begin
              low_q      <= req_low;
              retune_mhz <= req_pll;
              pmux_sel   <= PSEL_BACKUP;
              droop_wr   <= 1'b1;
              droop_data <= DROOP_VAL;
              state      <= ST_PARK;
            end
          end
        end
        ST_PARK: begin
          retune_req <= 1'b1;
          state      <= ST_TUNE;
        end
        ST_TUNE: begin
          if (pll_lock) begin
            retune_req <= 1'b0;
            state      <= ST_SSEL;
          end else if (expired) begin
            retune_req <= 1'b0;
            err        <= 1'b1;
            state      <= ST_IDLE;
          end
        end
        ST_SSEL: begin
          if (low_q) smux_sel <= SSEL_HALF;
          state <= ST_PSEL;
        end
        ST_PSEL: begin
          pmux_sel <= low_q ? PSEL_SEC : PSEL_DROOP;
          done     <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign req_ready = (state == ST_IDLE);
  assign tune_run  = (state == ST_TUNE);
endmodule

// File: rtl/cpu_clk_path_seq.sv
module cpu_clk_path_seq #(
  parameter int FW      = 12,
  parameter int TW      = 16,
  parameter int MIN_MHZ = 300,
  parameter int LOW_MHZ = 600,
  parameter int PLL_MIN = 600,
  parameter int PLL_MAX = 3000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [FW-1:0] req_mhz,
  input  logic [TW-1:0] lock_limit,
  input  logic          pll_lock,
  output logic          retune_req,
  output logic [FW:0]   retune_mhz,
  output logic [1:0]    pmux_sel,
  output logic [1:0]    smux_sel,
  output logic          droop_wr,
  output logic [3:0]    droop_data,
  output logic          busy,
  output logic          done,
  output logic          err
);
  logic        chk_ok, chk_low, tune_run, expired;
  logic [FW:0] chk_pll;

  cpu_clk_req_check #(
    .FW(FW), .MIN_MHZ(MIN_MHZ), .LOW_MHZ(LOW_MHZ),
    .PLL_MIN(PLL_MIN), .PLL_MAX(PLL_MAX)
  ) u_check (
    .mhz(req_mhz), .ok(chk_ok), .low(chk_low), .pll_mhz(chk_pll)
  );

  cpu_clk_lock_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .run(tune_run), .limit(lock_limit), .expired(expired)
  );

  cpu_clk_seq_fsm #(.FW(FW)) u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ok(chk_ok),
    .req_low(chk_low), .req_pll(chk_pll), .pll_lock(pll_lock),
    .expired(expired), .req_ready(req_ready), .tune_run(tune_run),
    .retune_req(retune_req), .retune_mhz(retune_mhz), .pmux_sel(pmux_sel),
    .smux_sel(smux_sel), .droop_wr(droop_wr), .droop_data(droop_data),
    .busy(busy), .done(done), .err(err)
  );
endmodule

// File: rtl/cpu_clk_path_seq_chk.sv
module cpu_clk_path_seq_chk #(
  parameter int FW = 12
) (
  input logic        clk,
  input logic        rst,
  input logic        req_ready,
  input logic        retune_req,
  input logic [1:0]  pmux_sel,
  input logic [1:0]  smux_sel,
  input logic        droop_wr,
  input logic [3:0]  droop_data,
  input logic        busy,
  input logic        done,
  input logic        err
);
  assert_droop_parked_R4: assert property (@(posedge clk) disable iff (rst)
    droop_wr |-> (pmux_sel == 2'd3 && droop_data == 4'hF));

  assert_retune_parked_R5: assert property (@(posedge clk) disable iff (rst)
    retune_req |-> pmux_sel == 2'd3);

  assert_smux_parked_R6: assert property (@(posedge clk) disable iff (rst)
    (smux_sel != $past(smux_sel)) |-> pmux_sel == 2'd3);

  assert_one_field_R10: assert property (@(posedge clk) disable iff (rst)
    !((smux_sel != $past(smux_sel)) && (pmux_sel != $past(pmux_sel))));

  assert_leave_backup_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(pmux_sel) == 2'd3 && pmux_sel != 2'd3) |-> done);

  assert_err_idle_R2: assert property (@(posedge clk) disable iff (rst)
    err |-> (!busy && req_ready));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind cpu_clk_path_seq cpu_clk_path_seq_chk #(.FW(FW)) i_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .retune_req(retune_req),
  .pmux_sel(pmux_sel), .smux_sel(smux_sel), .droop_wr(droop_wr),
  .droop_data(droop_data), .busy(busy), .done(done), .err(err)
);

// File: tb/test_cpu_clk_path_seq.sv
module test_cpu_clk_path_seq;
  localparam int FW = 12;
  localparam int TW = 16;
  localparam int LIMIT = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [FW-1:0] req_mhz = '0;
  logic [TW-1:0] lock_limit = TW'(LIMIT);
  logic          pll_lock = 1'b0;
  logic          retune_req;
  logic [FW:0]   retune_mhz;
  logic [1:0]    pmux_sel, smux_sel;
  logic          droop_wr;
  logic [3:0]    droop_data;
  logic          busy, done, err;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cpu_clk_path_seq i_cpu_clk_path_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_mhz(req_mhz), .lock_limit(lock_limit), .pll_lock(pll_lock),
    .retune_req(retune_req), .retune_mhz(retune_mhz), .pmux_sel(pmux_sel),
    .smux_sel(smux_sel), .droop_wr(droop_wr), .droop_data(droop_data),
    .busy(busy), .done(done), .err(err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input int mhz);
    @(negedge clk);
    req_valid = 1'b1;
    req_mhz   = FW'(mhz);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pmux", pmux_sel, 0);
    chk("R1 smux", smux_sel, 0);
    chk("R1 busy", busy, 0);
    chk("R1 ready", req_ready, 1);
  endtask

  task automatic t_reject(input int mhz, input string tag);
    int p0 = pmux_sel;
    int s0 = smux_sel;
    send(mhz);
    chk({tag, " err"}, err, 1);
    chk({tag, " busy"}, busy, 0);
    chk({tag, " pmux"}, pmux_sel, p0);
    chk({tag, " smux"}, smux_sel, s0);
    @(negedge clk);
    chk({tag, " err pulse"}, err, 0);
    chk({tag, " no retune"}, retune_req, 0);
  endtask

  task automatic t_switch(input int mhz, input bit poke_busy);
    bit low = (mhz < 600);
    int s0 = smux_sel;
    int pll = low ? 2 * mhz : mhz;
    send(mhz);
    chk("R4 park", pmux_sel, 3);
    chk("R4 droop_wr", droop_wr, 1);
    chk("R4 droop_data", droop_data, 15);
    chk("R9 ready low", req_ready, 0);
    @(negedge clk);
    chk("R5 retune_req", retune_req, 1);
    chk("R5 retune_mhz", retune_mhz, pll);
    chk("R4 droop pulse", droop_wr, 0);
    if (poke_busy) begin
      req_valid = 1'b1;
      req_mhz   = FW'(low ? 2500 : 350);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 retune_mhz kept", retune_mhz, pll);
      chk("R9 pmux kept", pmux_sel, 3);
    end
    repeat (2) @(negedge clk);
    pll_lock = 1'b1;
    @(negedge clk);
    chk("R5 retune drop", retune_req, 0);
    chk("R6 smux before", smux_sel, s0);
    chk("R6 pmux parked", pmux_sel, 3);
    @(negedge clk);
    chk(low ? "R6 smux half" : "R7 smux kept", smux_sel, low ? 1 : s0);
    chk("R10 pmux still parked", pmux_sel, 3);
    chk("R11 busy", busy, 1);
    @(negedge clk);
    chk(low ? "R6 pmux sec" : "R7 pmux droop", pmux_sel, low ? 0 : 2);
    chk("R11 done", done, 1);
    chk("R11 busy low", busy, 0);
    pll_lock = 1'b0;
    @(negedge clk);
    chk("R11 done pulse", done, 0);
    chk("R7 smux stable", smux_sel, low ? 1 : s0);
  endtask

  task automatic t_timeout();
    send(1000);
    @(negedge clk);
    chk("R8 retune up", retune_req, 1);
    repeat (LIMIT) @(negedge clk);
    chk("R8 no early err", err, 0);
    chk("R8 still busy", busy, 1);
    @(negedge clk);
    chk("R8 err", err, 1);
    chk("R8 pmux backup", pmux_sel, 3);
    chk("R8 retune down", retune_req, 0);
    chk("R8 busy low", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_reject(299, "R2");
    t_reject(3001, "R3");
    t_reject(4095, "R3 max");
    t_switch(400, 1'b0);
    t_switch(1500, 1'b1);
    t_switch(599, 1'b0);
    t_switch(600, 1'b0);
    t_switch(300, 1'b1);
    t_switch(3000, 1'b0);
    t_timeout();
    t_reject(100, "R2 after timeout");
    t_switch(800, 1'b0);
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule